// File: doc/BRIEF.md
# Bubble Queue Replacement Controller

This block holds the replacement state of a set-associative cache. Inside every set the ways are kept in an ordered queue. Position 0 is the top and position NUM_WAYS-1 is the bottom. The order is used only to choose which way to replace. Each set also carries one flag bit that records whether its latest lookup was a hit.

The cache pipeline presents one lookup result per cycle: the set index, a hit flag, the way that hit, and a fill request. On a hit, the hit way climbs exactly one position by trading places with its upper neighbour, so a way that hits often drifts toward the top. The flag chooses where the next victim comes from. When the flag is set, the bottom way is replaced, which protects the upper ways from blocks that are rarely used. When the flag is clear, the top way is replaced and the queue rotates up, which lets the set follow a change of working set.

A combinational read port returns, for any set, the way at a chosen position, the flag, and the way that the next fill would replace. Tags, data arrays and the pipeline itself are not part of this block.

Top module: `bq_bubble_repl`

## Requirements
- R1: After reset, every set holds way p at position p (way 0 on top) and every flag reads 0.
- R2: A valid hit on a way at position p>0 exchanges it with the way at position p-1. All other positions of that set keep their ways.
- R3: A valid hit on the way at position 0 leaves that set's order unchanged.
- R4: A valid hit sets the set's flag to 1. A valid miss clears it to 0, whether a fill is requested or not.
- R5: rd_victim is the way at position NUM_WAYS-1 when the flag of rd_set is 1, and the way at position 0 when the flag is 0.
- R6: A valid miss with fill while the flag is 0 evicts the top way. Every other way moves up one position and the evicted way re-enters at the bottom with its new block.
- R7: A valid miss with fill while the flag is 1 refills the bottom way in place, so the order is unchanged.
- R8: An access changes only the state of the set it addresses.
- R9: Each set's order is at all times a permutation of the ways 0..NUM_WAYS-1.
- R10: When acc_valid is 0, no order or flag changes, whatever acc_hit, acc_way and acc_fill carry. acc_fill is ignored on a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_valid | input | 1 | A lookup result is present this cycle |
| acc_set | input | SET_W | Set index of the lookup |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_way | input | WAY_W | Way that hit (used only on a hit) |
| acc_fill | input | 1 | On a miss, the missing block is filled into the victim way |
| rd_set | input | SET_W | Set to observe |
| rd_pos | input | WAY_W | Queue position to observe (0 = top) |
| rd_way | output | WAY_W | Way held at rd_pos of rd_set |
| rd_flag | output | 1 | Hit flag of rd_set |
| rd_victim | output | WAY_W | Way the next fill of rd_set would replace |

## Verification
An access is sampled on a rising edge. Its effect on the order, the flag and the victim is visible on the read port from that same edge onward, because the read port is combinational. The bench therefore applies each access for one cycle starting at a falling edge. It then holds acc_valid low while the monitor reads back every position of the touched set, and of a neighbouring set, on later falling edges. The read address is set at the falling edge and the outputs are compared shortly after it, so no comparison is made near an active edge.

// File: rtl/bq_pkg.sv
package bq_pkg;
  typedef enum logic [1:0] {
    BQ_NOP  = 2'd0,
    BQ_HIT  = 2'd1,
    BQ_FILL = 2'd2,
    BQ_MISS = 2'd3
  } bq_op_e;
endpackage

// File: rtl/bq_rst_sync.sv
module bq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/bq_classify.sv
module bq_classify
  import bq_pkg::*;
(
  input  logic   acc_valid,
  input  logic   acc_hit,
  input  logic   acc_fill,
  output bq_op_e op
);
  always_comb begin
    if (!acc_valid)    op = BQ_NOP;
    else if (acc_hit)  op = BQ_HIT;
    else if (acc_fill) op = BQ_FILL;
    else               op = BQ_MISS;
  end
endmodule

// File: rtl/bq_locate.sv
module bq_locate #(
  parameter int NUM_WAYS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0][WAY_W-1:0] order,
  input  logic [WAY_W-1:0]               way,
  output logic [WAY_W-1:0]               pos
);
  logic [NUM_WAYS-1:0] match;

  for (genvar p = 0; p < NUM_WAYS; p++) begin : g_cmp
    assign match[p] = (order[p] == way);
  end

  always_comb begin
    pos = '0;
    for (int p = 0; p < NUM_WAYS; p++) begin
      if (match[p]) pos = WAY_W'(p);
    end
  end
endmodule

// File: rtl/bq_reorder.sv
module bq_reorder
  import bq_pkg::*;
#(
  parameter int NUM_WAYS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  bq_op_e                         op,
  input  logic [NUM_WAYS-1:0][WAY_W-1:0] order_cur,
  input  logic                           flag_cur,
  input  logic [WAY_W-1:0]               hit_pos,
  output logic [NUM_WAYS-1:0][WAY_W-1:0] order_nxt,
  output logic                           flag_nxt
);
  logic [NUM_WAYS-1:0][WAY_W-1:0] rotated;
  logic [WAY_W-1:0]               above;

  for (genvar p = 0; p < NUM_WAYS; p++) begin : g_rot
    if (p == NUM_WAYS - 1) begin : g_last
      assign rotated[p] = order_cur[0];
    end else begin : g_mid
      assign rotated[p] = order_cur[p+1];
    end
  end

  assign above = hit_pos - 1'b1;

  always_comb begin
    order_nxt = order_cur;
    flag_nxt  = flag_cur;
    case (op)
      BQ_HIT: begin
        flag_nxt = 1'b1;
        if (hit_pos != '0) begin
          order_nxt[hit_pos] = order_cur[above];
          order_nxt[above]   = order_cur[hit_pos];
        end
      end
      BQ_FILL: begin
        flag_nxt = 1'b0;
        if (!flag_cur) order_nxt = rotated;
      end
      BQ_MISS: flag_nxt = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/bq_bubble_repl.sv
module bq_bubble_repl
  import bq_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 16,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             acc_fill,
  input  logic [SET_W-1:0] rd_set,
  input  logic [WAY_W-1:0] rd_pos,
  output logic [WAY_W-1:0] rd_way,
  output logic             rd_flag,
  output logic [WAY_W-1:0] rd_victim
);
  logic                           srst_n;
  bq_op_e                         op;
  logic [NUM_WAYS-1:0][WAY_W-1:0] order_q [NUM_SETS];
  logic [NUM_SETS-1:0]            flag_q;
  logic [NUM_WAYS-1:0][WAY_W-1:0] order_cur, order_nxt;
  logic                           flag_cur, flag_nxt;
  logic [WAY_W-1:0]               hit_pos;
  logic                           upd_en;

  bq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  bq_classify u_cls (
    .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_fill(acc_fill), .op(op)
  );

  assign order_cur = order_q[acc_set];
  assign flag_cur  = flag_q[acc_set];

  bq_locate #(.NUM_WAYS(NUM_WAYS)) u_loc (
    .order(order_cur), .way(acc_way), .pos(hit_pos)
  );

  bq_reorder #(.NUM_WAYS(NUM_WAYS)) u_reo (
    .op(op), .order_cur(order_cur), .flag_cur(flag_cur), .hit_pos(hit_pos),
    .order_nxt(order_nxt), .flag_nxt(flag_nxt)
  );

  assign upd_en = (op != BQ_NOP);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int p = 0; p < NUM_WAYS; p++) begin
          order_q[s][p] <= WAY_W'(p);
        end
      end
      flag_q <= '0;
    end else if (upd_en) begin
      order_q[acc_set]  <= order_nxt;
      flag_q[acc_set]   <= flag_nxt;
    end
  end

  assign rd_way    = order_q[rd_set][rd_pos];
  assign rd_flag   = flag_q[rd_set];
  assign rd_victim = flag_q[rd_set] ? order_q[rd_set][NUM_WAYS-1]
                                    : order_q[rd_set][0];
endmodule

// File: rtl/bq_bubble_checker.sv
module bq_bubble_checker #(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 16,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           acc_valid,
  input logic [SET_W-1:0]               acc_set,
  input logic                           acc_hit,
  input logic                           acc_fill,
  input logic [NUM_WAYS-1:0][WAY_W-1:0] order_q [NUM_SETS],
  input logic [NUM_SETS-1:0]            flag_q
);
  // R9: every set stays a permutation of the ways
  always @(posedge clk) begin
    if (rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        logic [NUM_WAYS-1:0] seen;
        seen = '0;
        for (int p = 0; p < NUM_WAYS; p++) seen[order_q[s][p]] = 1'b1;
        a_r9_permutation: assert ($countones(seen) == NUM_WAYS)
          else $error("set %0d order is not a permutation", s);
      end
    end
  end

  a_r4_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit) |=> flag_q[$past(acc_set)]);

  a_r4_miss_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit) |=> !flag_q[$past(acc_set)]);

  a_r10_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(flag_q));

  a_r7_bottom_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit && acc_fill && flag_q[acc_set])
      |=> (order_q[$past(acc_set)] == $past(order_q[acc_set])));
endmodule

bind bq_bubble_repl bq_bubble_checker #(
  .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
  .acc_hit(acc_hit), .acc_fill(acc_fill), .order_q(order_q), .flag_q(flag_q)
);

// File: tb/test_bq_bubble_repl.sv
`timescale 1ns/1ps
module test_bq_bubble_repl;
  localparam int NS = 8;
  localparam int NW = 16;
  localparam int SW = $clog2(NS);
  localparam int WW = $clog2(NW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0, acc_hit = 1'b0, acc_fill = 1'b0;
  logic [SW-1:0] acc_set = '0;
  logic [WW-1:0] acc_way = '0;
  logic [SW-1:0] rd_set = '0;
  logic [WW-1:0] rd_pos = '0;
  logic [WW-1:0] rd_way, rd_victim;
  logic          rd_flag;

  always #5 clk = ~clk;

  bq_bubble_repl #(.NUM_SETS(NS), .NUM_WAYS(NW)) i_bq_bubble_repl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_hit(acc_hit), .acc_way(acc_way), .acc_fill(acc_fill),
    .rd_set(rd_set), .rd_pos(rd_pos), .rd_way(rd_way), .rd_flag(rd_flag),
    .rd_victim(rd_victim)
  );

  typedef struct {
    int    set;
    int    pos;
    int    way;
    bit    flag;
    int    victim;
    string req;
  } item_t;

  item_t sb[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  int    mq[NS][NW];
  bit    mf[NS];

  // monitor: pops one expectation per falling edge and compares
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      rd_set = SW'(it.set);
      rd_pos = WW'(it.pos);
      #1;
      total++;
      if (int'(rd_way) != it.way || rd_flag != it.flag || int'(rd_victim) != it.victim) begin
        bad++;
        $display("FAIL %s set=%0d pos=%0d: way/flag/victim got %0d/%0d/%0d expected %0d/%0d/%0d",
                 it.req, it.set, it.pos, rd_way, rd_flag, rd_victim, it.way, it.flag, it.victim);
      end
    end
  end

  task automatic expect_set(input int s, input string req);
    for (int p = 0; p < NW; p++) begin
      item_t it;
      it.set = s; it.pos = p; it.way = mq[s][p]; it.flag = mf[s];
      it.victim = mf[s] ? mq[s][NW-1] : mq[s][0];   // R5
      it.req = req;
      sb.push_back(it);
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic model(input bit v, input int s, input bit h, input int w, input bit f);
    if (!v) return;
    if (h) begin
      int p = 0;
      for (int i = 0; i < NW; i++) if (mq[s][i] == w) p = i;
      if (p > 0) begin
        int t = mq[s][p];
        mq[s][p] = mq[s][p-1];
        mq[s][p-1] = t;
      end
      mf[s] = 1'b1;
    end else begin
      if (f && !mf[s]) begin
        int top = mq[s][0];
        for (int i = 0; i < NW-1; i++) mq[s][i] = mq[s][i+1];
        mq[s][NW-1] = top;
      end
      mf[s] = 1'b0;
    end
  endtask

  task automatic access(input bit v, input int s, input bit h, input int w, input bit f);
    @(negedge clk);
    acc_valid = v; acc_set = SW'(s); acc_hit = h; acc_way = WW'(w); acc_fill = f;
    @(negedge clk);
    acc_valid = 1'b0; acc_hit = 1'b0; acc_fill = 1'b0;
    model(v, s, h, w, f);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      mf[s] = 1'b0;
      for (int p = 0; p < NW; p++) mq[s][p] = p;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    expect_set(0, "R1");
    expect_set(NS-1, "R1");

    access(1, 2, 1, 5, 0);            // R2: way 5 at pos 5 moves to pos 4
    expect_set(2, "R2");
    expect_set(3, "R8");
    access(1, 2, 1, 5, 0);            // R2: climbs again to pos 3
    expect_set(2, "R2");
    access(1, 2, 1, 0, 1);            // R3: hit on top, fill ignored (R10)
    expect_set(2, "R3");
    access(1, 2, 0, 0, 1);            // R7: flag set -> refill bottom in place
    expect_set(2, "R7");
    access(1, 2, 0, 0, 1);            // R6: flag clear -> rotate up
    expect_set(2, "R6");
    access(1, 4, 1, 9, 0);
    access(1, 4, 0, 0, 0);            // R4: miss without fill clears flag
    expect_set(4, "R4");
    access(0, 4, 1, 15, 1);           // R10: invalid access has no effect
    expect_set(4, "R10");
    access(1, 5, 1, 15, 0);           // R5: victim from bottom when flag set
    expect_set(5, "R5");

    for (int n = 0; n < 200; n++) begin
      int s = $urandom_range(NS-1);
      bit h = ($urandom_range(9) < 6);
      access(1, s, h, $urandom_range(NW-1), $urandom_range(1));
      expect_set(s, "R9");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule